// File: doc/BRIEF.md
# EDO DRAM access controller

This block sits between a simple synchronous host port and a 32-bit array of extended-data-out DRAM. The array is made of four byte-wide devices that share one row strobe, one write-enable line and one multiplexed 11-bit address bus. Each device has its own column strobe. For each single-word request the controller places the row on the address bus and drops the row strobe. It then switches the bus to the column and drops the column strobes of the byte lanes involved. For reads it samples the data pins, and it then releases the strobes and counts out the precharge before the next request is taken. Every minimum strobe timing is a cycle-count parameter, so one netlist serves both speed grades at any clock rate.

The host holds `req_valid` with the request fields until `req_ack` pulses for one cycle; on a read, `rsp_rdata` is valid in that same cycle. Writes are always early writes. Write-enable goes low and the write data is driven before any column strobe falls, so the devices never drive their data pins during a write. A refresh sequencer elsewhere takes the DRAM pins through `ref_grant`. When a grant arrives, an access already in flight is finished first. After that no new request starts, and `dram_own` goes low so the sequencer knows the address and write-enable lines are its own.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row is `req_addr[20:10]` and is on `dram_addr` when `dram_ras_n` falls. The column is `{1'b0, req_addr[9:0]}` (top address bit zero) and is on `dram_addr` when the column strobes fall.
- R2: On a write, lane i of `dram_cas_n` (lane i gates data bits 8i+7..8i) goes low only if `req_be[i]` is 1. A write with `req_be` = 0 asserts no lane and leaves memory unchanged.
- R3: On a read, all four lanes go low together, `dram_we_n` stays 1 and `dram_dq_oe` stays 0 throughout.
- R4: On a write, `dram_we_n` is 0 and `dram_dq_oe` is 1 before the column strobes fall. Both hold until at least one cycle after the row and column strobes rise.
- R5: The column strobes fall exactly `T_RCD` cycles after `dram_ras_n` falls. The column address replaces the row `T_RAH` cycles after that fall.
- R6: `dram_ras_n` stays low for at least `T_RAS` cycles, and the column strobes stay low for at least `T_CAS` cycles.
- R7: Read data is sampled no earlier than one cycle after both the row-access deadline (`T_RAC` cycles after the row strobe falls) and the column-access deadline (`T_CAC` cycles after the column strobes fall). The sampled word is returned on `rsp_rdata` with `req_ack`.
- R8: `dram_ras_n` stays high for at least `T_RP` cycles between accesses. Successive row-strobe falls are at least `T_RC` cycles apart, even with back-to-back requests.
- R9: Each accepted request yields exactly one single-cycle `req_ack`. It comes in the cycle the strobes rise.
- R10: While `ref_grant` is 1, no new access starts, and once idle the block drives `dram_own` to 0 with all strobes high. An access already under way completes and is acknowledged.
- R11: After reset the strobes and write-enable are high, `dram_dq_oe` and `req_ack` are 0 and `dram_own` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address: row in bits 20..10, column in bits 9..0 |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for writes |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `req_ack` |
| ref_grant | input | 1 | Refresh sequencer owns the DRAM pins when the block is idle |
| dram_own | output | 1 | 1 while this block drives address and write-enable |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_o | output | 32 | Data toward the devices |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 32 | Data from the devices |

## Verification
The table exercises full-word writes, writes that touch only some lanes (one lane, alternating lanes, none) and reads after each. A wrong lane-to-data mapping or an ignored byte mask therefore shows up as a wrong word on readback. The addresses are zero, all ones and a mixed pattern, which separate the row and column fields and show whether the top address bit is zeroed in the column phase. The DRAM model returns a poison word until both access deadlines have passed, so a read sampled one cycle early is caught as bad data rather than passing by luck. The requests are chained with no idle gap, which pushes precharge and cycle time to their minimum. Refresh grants are given both while the block is idle and in the middle of an access, which tells a stall apart from an aborted cycle.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_PRECH  = 2'd3
   } edo_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_addr_mux.sv
// Selects row or zero-extended column onto the shared address pins.
module edo_addr_mux #(
   parameter int ROW_W = 11,
   parameter int COL_W = 10
) (
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             col_sel_i,
   output logic [ROW_W-1:0] bus_o
);
   logic [ROW_W-1:0] col_wide;

   generate
      if (COL_W < ROW_W) begin : g_pad
         assign col_wide = {{(ROW_W-COL_W){1'b0}}, col_i};
      end else begin : g_same
         assign col_wide = col_i[ROW_W-1:0];
      end
   endgenerate

   assign bus_o = col_sel_i ? col_wide : row_i;
endmodule

// File: rtl/edo_lane_strobes.sv
// One registered column strobe per byte lane.
module edo_lane_strobes #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic             release_i,
   input  logic             wr_i,
   input  logic [LANES-1:0] be_i,
   output logic [LANES-1:0] cas_n_o
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_q <= 1'b1;
            end else if (fire_i) begin
               lane_q <= wr_i ? ~be_i[i] : 1'b0;
            end else if (release_i) begin
               lane_q <= 1'b1;
            end
         end
         assign cas_n_o[i] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/edo_seq.sv
// Strobe sequencer: all spans derived from cycle-count parameters.
module edo_seq
   import edo_ctrl_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RAS = 5,
   parameter int T_RC  = 9,
   parameter int T_RCD = 2,
   parameter int T_RAH = 1,
   parameter int T_CAS = 2,
   parameter int T_RAC = 5,
   parameter int T_CAC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid_i,
   input  logic req_write_i,
   input  logic ref_grant_i,
   output logic accept_o,
   output logic ras_n_o,
   output logic we_n_o,
   output logic dq_oe_o,
   output logic col_sel_o,
   output logic cas_fire_o,
   output logic cas_release_o,
   output logic capture_o,
   output logic wr_o,
   output logic ack_o,
   output logic own_o
);
   localparam int SPAN_WR  = imax(T_RAS, T_RCD + T_CAS);
   localparam int SPAN_RD  = imax(SPAN_WR, imax(T_RAC + 1, T_RCD + T_CAC + 1));
   localparam int NEED_PRE = imax(T_RP, T_RC - SPAN_WR);
   localparam int PRE_CYC  = (NEED_PRE > 3) ? NEED_PRE - 2 : 1;
   localparam int MAXV     = imax(SPAN_RD, PRE_CYC);
   localparam int CNT_W    = $clog2(MAXV + 2);

   localparam logic [CNT_W-1:0] K_RAH  = CNT_W'(T_RAH);
   localparam logic [CNT_W-1:0] K_RCD  = CNT_W'(T_RCD);
   localparam logic [CNT_W-1:0] K_WR   = CNT_W'(SPAN_WR);
   localparam logic [CNT_W-1:0] K_RD   = CNT_W'(SPAN_RD);
   localparam logic [CNT_W-1:0] K_PRE  = CNT_W'(PRE_CYC);

   edo_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] k;
   logic [CNT_W-1:0] span;
   logic             wr_q;
   logic             at_end;

   assign k        = cnt + CNT_W'(1);
   assign span     = wr_q ? K_WR : K_RD;
   assign at_end   = (state == ST_ACTIVE) && (k == span);
   assign accept_o = (state == ST_IDLE) && req_valid_i && !ref_grant_i;
   assign own_o    = !((state == ST_IDLE) && ref_grant_i);

   assign cas_fire_o    = (state == ST_ACTIVE) && (k == K_RCD);
   assign cas_release_o = at_end;
   assign capture_o     = at_end && !wr_q;
   assign wr_o          = wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         wr_q      <= 1'b0;
         ras_n_o   <= 1'b1;
         we_n_o    <= 1'b1;
         dq_oe_o   <= 1'b0;
         col_sel_o <= 1'b0;
         ack_o     <= 1'b0;
      end else begin
         ack_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept_o) begin
                  wr_q      <= req_write_i;
                  col_sel_o <= 1'b0;
                  state     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               ras_n_o <= 1'b0;
               we_n_o  <= ~wr_q;
               dq_oe_o <= wr_q;
               cnt     <= '0;
               state   <= ST_ACTIVE;
            end
            ST_ACTIVE: begin
               if (k == K_RAH) col_sel_o <= 1'b1;
               if (at_end) begin
                  ras_n_o <= 1'b1;
                  ack_o   <= 1'b1;
                  cnt     <= '0;
                  state   <= ST_PRECH;
               end else begin
                  cnt <= k;
               end
            end
            ST_PRECH: begin
               if (cnt == '0) begin
                  we_n_o  <= 1'b1;
                  dq_oe_o <= 1'b0;
               end
               cnt <= k;
               if (k >= K_PRE) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int T_RP   = 3,
   parameter int T_RAS  = 5,
   parameter int T_RC   = 9,
   parameter int T_RCD  = 2,
   parameter int T_RAH  = 1,
   parameter int T_CAS  = 2,
   parameter int T_RAC  = 5,
   parameter int T_CAC  = 2,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              ref_grant,
   output logic              dram_own,
   output logic              dram_ras_n,
   output logic [LANES-1:0]  dram_cas_n,
   output logic              dram_we_n,
   output logic [ROW_W-1:0]  dram_addr,
   output logic [DATA_W-1:0] dram_dq_o,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_i
);
   generate
      if (COL_W >= ROW_W) begin : g_bad_col
         $error("COL_W must be narrower than ROW_W");
      end
      if (T_RAH < 1 || T_RAH >= T_RCD) begin : g_bad_rah
         $error("T_RAH must be at least 1 and below T_RCD");
      end
      if (T_RP < 1 || T_CAS < 1 || T_RAS < 1) begin : g_bad_min
         $error("strobe counts must be positive");
      end
   endgenerate

   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] rdata_q;
   logic accept, col_sel, cas_fire, cas_release, capture, wr;

   edo_seq #(
      .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RCD(T_RCD),
      .T_RAH(T_RAH), .T_CAS(T_CAS), .T_RAC(T_RAC), .T_CAC(T_CAC)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write), .ref_grant_i(ref_grant),
      .accept_o(accept), .ras_n_o(dram_ras_n), .we_n_o(dram_we_n),
      .dq_oe_o(dram_dq_oe), .col_sel_o(col_sel), .cas_fire_o(cas_fire),
      .cas_release_o(cas_release), .capture_o(capture), .wr_o(wr),
      .ack_o(req_ack), .own_o(dram_own)
   );

   edo_lane_strobes #(.LANES(LANES)) lanes_i (
      .clk(clk), .rst_n(rst_n), .fire_i(cas_fire), .release_i(cas_release),
      .wr_i(wr), .be_i(be_q), .cas_n_o(dram_cas_n)
   );

   edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) mux_i (
      .row_i(row_q), .col_i(col_q), .col_sel_i(col_sel), .bus_o(dram_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            row_q   <= req_addr[ADDR_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         if (capture) rdata_q <= dram_dq_i;
      end
   end

   assign dram_dq_o = wdata_q;
   assign rsp_rdata = rdata_q;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
   parameter int LANES = 4,
   parameter int T_RP  = 3,
   parameter int T_RAS = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ack,
   input logic             dram_own,
   input logic             dram_ras_n,
   input logic [LANES-1:0] dram_cas_n,
   input logic             dram_we_n,
   input logic             dram_dq_oe
);
   localparam logic [LANES-1:0] ALL_HI = '1;
   logic [15:0] lo_cnt, hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= 16'hFFFF;
      end else if (dram_ras_n) begin
         lo_cnt <= '0;
         hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
      end else begin
         hi_cnt <= '0;
         lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1;
      end
   end

   // R6: row strobe low long enough
   a_r6_ras_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> lo_cnt >= 16'(T_RAS));
   // R8: precharge honoured
   a_r8_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> hi_cnt >= 16'(T_RP));
   // R3: read cycles strobe every lane
   a_r3_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cas_n != ALL_HI && dram_we_n) |-> dram_cas_n == '0);
   // R3: no data driven while write-enable is high
   a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      dram_we_n |-> !dram_dq_oe);
   // R4: early write set up before the column strobe falls
   a_r4_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cas_n != ALL_HI && $past(dram_cas_n) == ALL_HI && !dram_we_n)
      |-> ($past(!dram_we_n) && $past(dram_dq_oe)));
   // R5: column strobes only inside a row cycle
   a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cas_n != ALL_HI) |-> !dram_ras_n);
   // R9: single-cycle completion
   a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   // R10: pins quiet while handed over
   a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_own |-> (dram_ras_n && dram_cas_n == ALL_HI));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
   .LANES(LANES), .T_RP(T_RP), .T_RAS(T_RAS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .dram_own(dram_own),
   .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
   .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
   localparam int T_RP = 3, T_RAS = 5, T_RC = 9, T_RCD = 2, T_RAH = 1;
   localparam int T_CAS = 2, T_RAC = 5, T_CAC = 2;
   localparam logic [31:0] POISON = 32'hBAD0_BAD0;

   typedef struct packed {
      logic        wr;
      logic [20:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 21'h00ABCD, 32'h1122_3344, 4'hF, 32'h0},
      '{1'b0, 21'h00ABCD, 32'h0,         4'h0, 32'h1122_3344},
      '{1'b1, 21'h00ABCD, 32'hAABB_CCDD, 4'h5, 32'h0},
      '{1'b0, 21'h00ABCD, 32'h0,         4'h0, 32'h11BB_33DD},
      '{1'b1, 21'h1FFFFF, 32'hCAFE_F00D, 4'hF, 32'h0},
      '{1'b1, 21'h000000, 32'h0102_0304, 4'h8, 32'h0},
      '{1'b0, 21'h1FFFFF, 32'h0,         4'h0, 32'hCAFE_F00D},
      '{1'b0, 21'h000000, 32'h0,         4'h0, 32'h0100_0000},
      '{1'b1, 21'h00ABCD, 32'hFFFF_FFFF, 4'h0, 32'h0},
      '{1'b0, 21'h00ABCD, 32'h0,         4'h0, 32'h11BB_33DD}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic req_ack, dram_own, dram_ras_n, dram_we_n, dram_dq_oe;
   logic [3:0]  dram_cas_n;
   logic [10:0] dram_addr;
   logic [31:0] dram_dq_o, rsp_rdata;
   logic [31:0] dram_dq_i = POISON;

   always #2 clk = ~clk;

   edo_dram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ack(req_ack), .rsp_rdata(rsp_rdata), .ref_grant(ref_grant),
      .dram_own(dram_own), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_o(dram_dq_o),
      .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
   );

   int checks = 0, failures = 0, cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- DRAM model, sampled on falling clock edges
   logic [31:0] mem [int unsigned];
   logic        ras_prev = 1'b1;
   logic [3:0]  cas_prev = 4'hF;
   int rcnt = 0, ccnt = 0, hcnt = 1000, low_len = 0, cas_len = 0;
   int hi_rec = 0, rc_rec = 0, rcd_rec = 0, fall_cnt = 0, ack_cnt = 0;
   logic [10:0] row_rec = '0, col_rec = '0;
   logic [3:0]  lanes_rec = '0;
   logic we_cas = 1'b1, oe_cas = 1'b0, we_rise = 1'b1, oe_rise = 1'b0;
   logic [31:0] rd_word = '0;

   always @(negedge clk) begin
      int unsigned key;
      logic [31:0] w;
      cyc++;
      if (req_ack) ack_cnt++;
      if (rst_n) begin
         if (!dram_ras_n) begin
            if (ras_prev) begin
               rcnt = 1; row_rec = dram_addr; lanes_rec = '0;
               hi_rec = hcnt; rc_rec = hcnt + low_len; hcnt = 0; fall_cnt++;
            end else rcnt++;
         end else begin
            if (!ras_prev) begin
               low_len = rcnt; we_rise = dram_we_n; oe_rise = dram_dq_oe;
            end
            if (hcnt < 1000) hcnt++;
         end
         if (dram_cas_n != 4'hF) begin
            if (cas_prev == 4'hF) begin
               ccnt = 1; lanes_rec = ~dram_cas_n; col_rec = dram_addr;
               rcd_rec = rcnt - 1; we_cas = dram_we_n; oe_cas = dram_dq_oe;
               key = {21'd0, row_rec, col_rec};
               w = mem.exists(key) ? mem[key] : 32'h0;
               if (!dram_we_n) begin
                  for (int i = 0; i < 4; i++)
                     if (!dram_cas_n[i])
                        w[i*8 +: 8] = dram_dq_oe ? dram_dq_o[i*8 +: 8] : 8'hEE;
                  mem[key] = w;
               end
               rd_word = w;
            end else ccnt++;
         end else if (cas_prev != 4'hF) begin
            cas_len = ccnt;
         end
         dram_dq_i = (!dram_ras_n && dram_cas_n != 4'hF && dram_we_n &&
                      rcnt >= T_RAC + 1 && ccnt >= T_CAC + 1) ? rd_word : POISON;
      end
      ras_prev = dram_ras_n;
      cas_prev = dram_cas_n;
      if (cyc == 20000) begin
         failures++;
         $display("FAIL watchdog R9 no completion actual=%0d expected=%0d", cyc, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_ack(output logic [31:0] rd);
      do @(negedge clk); while (!req_ack);
      rd = rsp_rdata;
   endtask

   initial begin
      logic [31:0] rd;
      int fc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(dram_ras_n == 1'b1 && dram_we_n == 1'b1, "R11", "strobes/we", {30'd0, dram_ras_n, dram_we_n}, 32'h3);
      chk(dram_cas_n == 4'hF, "R11", "cas lanes", {28'd0, dram_cas_n}, 32'hF);
      chk(!dram_dq_oe && !req_ack && dram_own, "R11", "oe/ack/own",
          {29'd0, dram_dq_oe, req_ack, dram_own}, 32'h1);

      // Table walk, requests chained without idle gaps
      for (int n = 0; n < NV; n++) begin
         vec_t v = VECS[n];
         req_write = v.wr; req_addr = v.addr; req_wdata = v.data; req_be = v.be;
         req_valid = 1'b1;
         wait_ack(rd);
         if (n == NV - 1) req_valid = 1'b0;
         @(negedge clk);
         chk(!req_ack, "R9", "ack width", {31'd0, req_ack}, 32'h0);
         chk(row_rec == v.addr[20:10], "R1", "row", {21'd0, row_rec}, {21'd0, v.addr[20:10]});
         chk(low_len >= T_RAS, "R6", "ras low", low_len, T_RAS);
         if (n > 0) begin
            chk(hi_rec >= T_RP, "R8", "precharge", hi_rec, T_RP);
            chk(rc_rec >= T_RC, "R8", "cycle time", rc_rec, T_RC);
         end
         if (v.wr) begin
            chk(lanes_rec == v.be, "R2", "write lanes", {28'd0, lanes_rec}, {28'd0, v.be});
            chk(we_rise == 1'b0 && oe_rise == 1'b1, "R4", "we/oe at strobe rise",
                {30'd0, we_rise, oe_rise}, 32'h1);
         end else begin
            chk(lanes_rec == 4'hF, "R3", "read lanes", {28'd0, lanes_rec}, 32'hF);
            chk(rd == v.exp, "R7", "read data", rd, v.exp);
         end
         if (lanes_rec != 4'h0) begin
            chk(col_rec == {1'b0, v.addr[9:0]}, "R1", "column", {21'd0, col_rec}, {21'd0, 1'b0, v.addr[9:0]});
            chk(rcd_rec == T_RCD, "R5", "ras to cas", rcd_rec, T_RCD);
            chk(cas_len >= T_CAS, "R6", "cas low", cas_len, T_CAS);
            if (v.wr) chk(we_cas == 1'b0 && oe_cas == 1'b1, "R4", "early write setup",
                          {30'd0, we_cas, oe_cas}, 32'h1);
            else chk(we_cas == 1'b1 && oe_cas == 1'b0, "R3", "read we/oe",
                     {30'd0, we_cas, oe_cas}, 32'h2);
         end
      end

      // R5: column on the bus exactly T_RAH cycles after the row strobe
      req_write = 1'b0; req_addr = 21'h155555; req_valid = 1'b1;
      do @(negedge clk); while (dram_ras_n);
      chk(dram_addr == 11'h555, "R5", "row held", {21'd0, dram_addr}, 32'h555);
      repeat (T_RAH) @(negedge clk);
      chk(dram_addr == 11'h155, "R5", "column after hold", {21'd0, dram_addr}, 32'h155);
      wait_ack(rd);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);

      // R10: grant while idle stalls the request
      ref_grant = 1'b1;
      @(negedge clk);
      fc = fall_cnt;
      req_write = 1'b1; req_addr = 21'h000123; req_wdata = 32'h5A5A_A5A5; req_be = 4'hF;
      req_valid = 1'b1;
      repeat (8) @(negedge clk);
      chk(fall_cnt == fc, "R10", "no start under grant", fall_cnt, fc);
      chk(!dram_own, "R10", "ownership released", {31'd0, dram_own}, 32'h0);
      ref_grant = 1'b0;
      wait_ack(rd);
      req_valid = 1'b0;
      chk(fall_cnt == fc + 1, "R10", "starts after grant", fall_cnt, fc + 1);

      // R10: grant mid-access lets the access finish
      repeat (4) @(negedge clk);
      fc = ack_cnt;
      req_write = 1'b0; req_addr = 21'h000123; req_valid = 1'b1;
      do @(negedge clk); while (dram_ras_n);
      ref_grant = 1'b1;
      @(negedge clk);
      chk(dram_own, "R10", "own during access", {31'd0, dram_own}, 32'h1);
      wait_ack(rd);
      req_valid = 1'b0;
      chk(rd == 32'h5A5A_A5A5, "R10", "in-flight read completes", rd, 32'h5A5A_A5A5);
      repeat (6) @(negedge clk);
      chk(!dram_own && dram_ras_n, "R10", "idle under grant",
          {30'd0, dram_own, dram_ras_n}, 32'h1);
      chk(ack_cnt == fc + 1, "R9", "one ack per request", ack_cnt, fc + 1);
      ref_grant = 1'b0;
      repeat (3) @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule